// File: doc/BRIEF.md
# Serial Decimal Field Add/Subtract Sequencer

This block adds or subtracts two signed decimal numbers that live as variable-length fields in a small internal digit memory. Each field is stored as an unsigned magnitude, one decimal digit per cell. The minus flag sits on the cell that holds the units digit. A word-mark bit on the most significant cell ends the field. On a start pulse the sequencer reads both units cells. From the requested operation and the two signs it decides whether to add the magnitudes directly or to add the nines' complement of the first operand. It then walks both fields one digit per clock cycle, units first, and writes each result digit back over the second operand.

Every digit goes through a qui-binary adder. Each operand digit is split into a one-hot "even part" (0, 2, 4, 6, 8) and a one-hot "odd bit" (0 or 1). The two parts are summed in separate small adders and the sum is recombined into a digit code. A digit result that is not one-hot in both parts is a fault: the operation stops and reports an error. When complement arithmetic gives a negative result, the sequencer inverts the result sign. It then makes two more digit-serial passes over the result field. The first pass, from the top down, replaces each digit with its nines' complement. The second pass, from the units up, adds one. The field then holds the true magnitude.

A host loads the fields through a write port while the block is idle, pulses start, waits for done and reads the result back through a read port.

Top module: `dec_field_addsub`

## Requirements
- R1: After reset, busy, done and error are all low.
- R2: Digit codes 1 to 9 stand for their own values. Codes 1010 and 0000 both mean zero. Codes 1011 to 1111 mean 3 to 7. Every zero digit the block writes is coded 1010.
- R3: A cell is 6 bits wide: bit 5 is the word mark, bit 4 is the minus flag and bits 3:0 are the digit code. A field's units digit is at its start address. More significant digits sit at successively lower addresses, and the field ends at the first cell, inclusive, whose bit 5 is set. The minus flag is read only from the units cell.
- R4: With op_sub = 1 the result is B − A, and with op_sub = 0 it is B + A (A at a_start, B at b_start). When op_sub XOR signA XOR signB is 0, the magnitudes are added modulo 10^n, where n is the length of the B field, and the result sign is B's sign.
- R5: Otherwise the block adds B, the nines' complement of A and a carry-in of 1, and drops the final carry. If that carry is 1, the result is |B| − |A| with B's sign.
- R6: If the complement add gives no final carry, the result sign is the inverse of B's sign and the stored magnitude is |A| − |B|.
- R7: Any A digits past A's word mark count as zero. A digits beyond the length of B are not used.
- R8: The result overwrites the B field. Its word marks are kept, the minus flag is set only on the units cell, and the A field is not changed when it does not overlap B.
- R9: busy rises on the edge that samples start while idle. done is a one-cycle pulse on the (n+1)th edge after that one, or on the (3n+1)th edge when the R6 correction runs. busy is low while done is high.
- R10: start and load writes are ignored while an operation is in progress.
- R11: error rises together with done when a digit result fails the one-hot check, and the operation stops there. For any 4-bit input codes the check never fails, so error stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_sub | input | 1 | 1 = subtract A from B, 0 = add A to B |
| a_start | input | ADDR_W | Address of A's units cell |
| b_start | input | ADDR_W | Address of B's units cell (result destination) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Digit fault seen in the last operation |
| ld_we | input | 1 | Load write enable (idle only) |
| ld_addr | input | ADDR_W | Load write address |
| ld_data | input | 6 | Load cell value |
| rd_addr | input | ADDR_W | Read-back address |
| rd_data | output | 6 | Cell value at rd_addr (combinational) |

## Verification
The hardest situation to reach from the ports is the sign-correction path. It needs the effective operation to be a complement add with |A| > |B| after A has been truncated or zero-extended to B's length, and it must also cover single-digit fields and fields of unequal length. The directed tasks create this with chosen operand pairs, one of them with a single-digit B, and the random task mixes the signs and lengths so that about a quarter of its runs take that path. A separate task overrides A's units cell with out-of-range codes to reach the translator's unusual mappings.

// File: rtl/qbd_pkg.sv
// Shared types and helpers for the decimal field sequencer.
// Assumes 4-bit digit codes with zero stored as 1010.
package qbd_pkg;
    localparam int CODE_W  = 4;
    localparam int CELL_W  = 6;
    localparam int WM_BIT  = 5;
    localparam int NEG_BIT = 4;
    localparam logic [CODE_W-1:0] ZERO_CODE = 4'b1010;

    // One-hot even part (index k means value 2k) and one-hot odd bit
    typedef struct packed {
        logic [4:0] q;
        logic [1:0] b;
    } qb_t;

    typedef enum logic [2:0] {
        S_IDLE, S_SIGN, S_ADD_LOOP, S_RECOMP1, S_RECOMP2, S_DONE
    } seq_state_t;

    // Map any 4-bit code to a valid split digit (1010->0, 11..15 -> 3..7)
    function automatic qb_t code_to_qb(input logic [CODE_W-1:0] code);
        logic [3:0] v;
        qb_t r;
        if (code == ZERO_CODE)  v = 4'd0;
        else if (code > 4'd10)  v = code - 4'd8;
        else                    v = code;
        r.q = 5'b00001 << v[3:1];
        r.b = v[0] ? 2'b10 : 2'b01;
        return r;
    endfunction

    // Nines' complement in split form: swap odd bit, mirror even part
    function automatic qb_t qb_nines(input qb_t x);
        qb_t r;
        r.b = {x.b[0], x.b[1]};
        for (int k = 0; k < 5; k++) r.q[k] = x.q[4-k];
        return r;
    endfunction

    // Recombine a split digit into a code, zero written as 1010
    function automatic logic [CODE_W-1:0] qb_to_code(input qb_t x);
        logic [3:0] v;
        v = 4'd0;
        for (int k = 0; k < 5; k++)
            if (x.q[k]) v = v | 4'(2 * k);
        v = v | {3'b000, x.b[1]};
        return (v == 4'd0) ? ZERO_CODE : v;
    endfunction
endpackage

// File: rtl/qbd_field_mem.sv
// Digit cell memory: one synchronous write port, three combinational
// read ports. No reset; contents are defined by the loader.
module qbd_field_mem #(
    parameter int ADDR_W = 6,
    parameter int W      = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [ADDR_W-1:0] ra_a,
    output logic [W-1:0]      rd_a,
    input  logic [ADDR_W-1:0] ra_b,
    output logic [W-1:0]      rd_b,
    input  logic [ADDR_W-1:0] ra_x,
    output logic [W-1:0]      rd_x
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [W-1:0] cells [DEPTH];

    // Store one cell per cycle
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rd_a = cells[ra_a];
    assign rd_b = cells[ra_b];
    assign rd_x = cells[ra_x];
endmodule

// File: rtl/qbd_digit_add.sv
// One-digit qui-binary adder with optional nines' complement of the
// first operand and a validity check on the recombined sum.
// Purely combinational; assumes nothing about input code ranges.
module qbd_digit_add
    import qbd_pkg::*;
(
    input  logic [CODE_W-1:0] a_code,
    input  logic [CODE_W-1:0] b_code,
    input  logic              comp,
    input  logic              cin,
    output logic [CODE_W-1:0] sum_code,
    output logic              cout,
    output logic              fault
);
    qb_t        a_qb, b_qb, res;
    logic [4:0] qsum;
    logic       qcarry;
    logic [1:0] odd_tot;

    assign a_qb = comp ? qb_nines(code_to_qb(a_code)) : code_to_qb(a_code);
    assign b_qb = code_to_qb(b_code);

    // Even-part matrix: every pair of set lines drives its sum line
    always_comb begin
        qsum   = '0;
        qcarry = 1'b0;
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                qsum[(i + j) % 5] = qsum[(i + j) % 5] | (a_qb.q[i] & b_qb.q[j]);
                if (i + j >= 5) qcarry = qcarry | (a_qb.q[i] & b_qb.q[j]);
            end
        end
    end

    assign odd_tot = 2'(a_qb.b[1]) + 2'(b_qb.b[1]) + 2'(cin);

    // Odd-bit carry moves the even part up one step (8 wraps to 0)
    always_comb begin
        res.b = odd_tot[0] ? 2'b10 : 2'b01;
        res.q = odd_tot[1] ? {qsum[3:0], qsum[4]} : qsum;
    end

    assign cout     = qcarry | (odd_tot[1] & qsum[4]);
    assign fault    = ($countones(res.q) != 1) || ($countones(res.b) != 1);
    assign sum_code = qb_to_code(res);
endmodule

// File: rtl/dec_field_addsub.sv
// Digit-serial signed decimal field add/subtract over an internal cell
// memory. Result overwrites the B field. Assumes each field has a word
// mark within the memory and that the host loads only while idle.
module dec_field_addsub
    import qbd_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_sub,
    input  logic [ADDR_W-1:0] a_start,
    input  logic [ADDR_W-1:0] b_start,
    output logic              busy,
    output logic              done,
    output logic              error,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CELL_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CELL_W-1:0] rd_data
);
    seq_state_t        state;
    logic [ADDR_W-1:0] a_ptr, b_ptr, unit_ptr;
    logic              op_q, comp, rsign, carry, a_end, err_q;
    logic [CELL_W-1:0] cell_a, cell_b, wr_cell;
    logic [CODE_W-1:0] add_a, add_b, sum_code;
    logic              add_comp, add_cin, add_cout, add_fault;
    logic              walking, seq_we, mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [CELL_W-1:0] mem_wdata;

    assign walking = (state == S_ADD_LOOP) || (state == S_RECOMP1) || (state == S_RECOMP2);

    // Select digit-adder operands for the current pass
    always_comb begin
        add_a    = cell_b[CODE_W-1:0];
        add_b    = ZERO_CODE;
        add_comp = 1'b0;
        add_cin  = carry;
        case (state)
            S_ADD_LOOP: begin
                add_a    = a_end ? ZERO_CODE : cell_a[CODE_W-1:0];
                add_b    = cell_b[CODE_W-1:0];
                add_comp = comp;
            end
            S_RECOMP1: begin
                add_comp = 1'b1;
                add_cin  = 1'b0;
            end
            default: ;
        endcase
    end

    qbd_digit_add u_add (
        .a_code(add_a), .b_code(add_b), .comp(add_comp), .cin(add_cin),
        .sum_code(sum_code), .cout(add_cout), .fault(add_fault)
    );

    // Result cell keeps the word mark; minus flag only on the units cell
    assign wr_cell   = {cell_b[WM_BIT], (b_ptr == unit_ptr) & rsign, sum_code};
    assign seq_we    = walking & ~add_fault;
    assign mem_we    = seq_we | (ld_we & (state == S_IDLE));
    assign mem_waddr = seq_we ? b_ptr : ld_addr;
    assign mem_wdata = seq_we ? wr_cell : ld_data;

    qbd_field_mem #(.ADDR_W(ADDR_W), .W(CELL_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .ra_a(a_ptr), .rd_a(cell_a), .ra_b(b_ptr), .rd_b(cell_b),
        .ra_x(rd_addr), .rd_x(rd_data)
    );

    // Sequencer: sign decision, digit loop, two correction passes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            a_ptr    <= '0;
            b_ptr    <= '0;
            unit_ptr <= '0;
            op_q     <= 1'b0;
            comp     <= 1'b0;
            rsign    <= 1'b0;
            carry    <= 1'b0;
            a_end    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    a_ptr    <= a_start;
                    b_ptr    <= b_start;
                    unit_ptr <= b_start;
                    op_q     <= op_sub;
                    err_q    <= 1'b0;
                    state    <= S_SIGN;
                end
                S_SIGN: begin
                    comp  <= op_q ^ cell_a[NEG_BIT] ^ cell_b[NEG_BIT];
                    carry <= op_q ^ cell_a[NEG_BIT] ^ cell_b[NEG_BIT];
                    rsign <= cell_b[NEG_BIT];
                    a_end <= 1'b0;
                    state <= S_ADD_LOOP;
                end
                S_ADD_LOOP: begin
                    if (add_fault) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        carry <= add_cout;
                        a_end <= a_end | cell_a[WM_BIT];
                        if (cell_b[WM_BIT]) begin
                            if (comp && !add_cout) begin
                                rsign <= ~rsign;
                                state <= S_RECOMP1;
                            end else begin
                                state <= S_DONE;
                            end
                        end else begin
                            a_ptr <= a_ptr - 1'b1;
                            b_ptr <= b_ptr - 1'b1;
                        end
                    end
                end
                S_RECOMP1: begin
                    if (add_fault) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (b_ptr == unit_ptr) begin
                        carry <= 1'b1;
                        state <= S_RECOMP2;
                    end else begin
                        b_ptr <= b_ptr + 1'b1;
                    end
                end
                S_RECOMP2: begin
                    if (add_fault) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        carry <= add_cout;
                        if (cell_b[WM_BIT]) state <= S_DONE;
                        else                b_ptr <= b_ptr - 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy  = walking | (state == S_SIGN);
    assign done  = (state == S_DONE);
    assign error = err_q;
endmodule

// File: rtl/dec_field_addsub_chk.sv
// Protocol checker for the field sequencer, attached by bind.
module dec_field_addsub_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic error
);
    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);
    // R9
    busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R11
    error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done);
    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

bind dec_field_addsub dec_field_addsub_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .error(error)
);

// File: tb/dec_field_addsub_test.sv
// Directed bench: one task per scenario, each checking its own results.
module dec_field_addsub_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int A_UNIT = 20;
    localparam int B_UNIT = 50;

    logic clk, rst_n, start, op_sub, busy, done, error, ld_we;
    logic [AW-1:0] a_start, b_start, ld_addr, rd_addr;
    logic [5:0] ld_data, rd_data;
    int n_total, n_fail, cyc;

    dec_field_addsub #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
        .a_start(a_start), .b_start(b_start), .busy(busy), .done(done),
        .error(error), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_total++; n_fail++;
            $display("FAIL R9 watchdog: got %0d cycles expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    function automatic longint p10(int n);
        longint r = 1;
        for (int i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_cell(int addr, logic [5:0] data);
        ld_we = 1'b1; ld_addr = AW'(addr); ld_data = data;
        @(posedge clk); #1;
        ld_we = 1'b0;
    endtask

    task automatic load_field(int unit, int len, longint mag, bit neg);
        for (int i = 0; i < len; i++) begin
            int d = int'((mag / p10(i)) % 10);
            wr_cell(unit - i, {i == len - 1, (i == 0) && neg, (d == 0) ? 4'd10 : 4'(d)});
        end
    endtask

    // Read a field; fmt_ok covers marks/flags (R8), code_ok covers zero coding (R2)
    task automatic read_field(int unit, int len, output longint mag, output bit neg,
                              output bit fmt_ok, output bit code_ok);
        mag = 0; neg = 0; fmt_ok = 1; code_ok = 1;
        for (int i = 0; i < len; i++) begin
            logic [5:0] c;
            rd_addr = AW'(unit - i); #1; c = rd_data;
            if (c[3:0] == 4'd0 || c[3:0] > 4'd10) code_ok = 0;
            if (c[5] != (i == len - 1)) fmt_ok = 0;
            if (i > 0 && c[4]) fmt_ok = 0;
            if (i == 0) neg = c[4];
            mag += ((c[3:0] == 4'd10) ? 0 : longint'(c[3:0])) * p10(i);
        end
        @(posedge clk); #1;
    endtask

    task automatic run_op(bit op, bit disturb, output int cycles, output bit busy_seen);
        op_sub = op; a_start = AW'(A_UNIT); b_start = AW'(B_UNIT);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        cycles = 0; busy_seen = busy;
        while (cycles < 200) begin
            if (cycles == 2 && disturb) begin
                start = 1'b1; ld_we = 1'b1;
                ld_addr = AW'(B_UNIT); ld_data = 6'h2F;
            end
            @(posedge clk); #1;
            start = 1'b0; ld_we = 1'b0;
            cycles++;
            if (done) break;
        end
    endtask

    // One operation against the integer reference
    task automatic t_op(bit op, int la, longint ma, bit na, int lb, longint mb, bit nb,
                        int a_ovr, bit disturb);
        longint ma_t, em, gm, am;
        bit es, rc, gs, an, fok, cok, bsy, err_end;
        int cyc_n;
        string tag;
        load_field(A_UNIT, la, ma, na);
        if (a_ovr >= 0) wr_cell(A_UNIT, {la == 1, na, 4'(a_ovr)});
        load_field(B_UNIT, lb, mb, nb);
        ma_t = ma % p10(lb);
        rc = 0;
        if ((op ^ na ^ nb) == 1'b0) begin
            em = (mb + ma_t) % p10(lb); es = nb; tag = "R4";
        end else if (mb >= ma_t) begin
            em = mb - ma_t; es = nb; tag = "R5";
        end else begin
            em = ma_t - mb; es = !nb; rc = 1; tag = "R6";
        end
        if (disturb) tag = "R10";
        else if (a_ovr >= 0) tag = "R2";
        else if (la != lb) tag = "R7";
        run_op(op, disturb, cyc_n, bsy);
        err_end = error;
        @(posedge clk); #1;
        read_field(B_UNIT, lb, gm, gs, fok, cok);
        check(gm == em, tag, "result magnitude", gm, em);
        check(gs == es, "R3", "result minus flag", longint'(gs), longint'(es));
        check(fok, "R8", "result word marks and flags", longint'(fok), 1);
        check(cok, "R2", "result digit coding", longint'(cok), 1);
        check(cyc_n == (rc ? 3 * lb + 1 : lb + 1), "R9", "cycles to done",
              cyc_n, rc ? 3 * lb + 1 : lb + 1);
        check(bsy, "R9", "busy after start", longint'(bsy), 1);
        check(!err_end, "R11", "error flag", longint'(err_end), 0);
        if (a_ovr < 0) begin
            read_field(A_UNIT, la, am, an, fok, cok);
            check(am == ma && an == na && fok, "R8", "A field unchanged", am, ma);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start = 0; op_sub = 0; ld_we = 0; ld_addr = '0; ld_data = '0;
        rd_addr = '0; a_start = '0; b_start = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check(!busy && !done && !error, "R1", "idle outputs after reset",
              longint'({busy, done, error}), 0);
        @(posedge clk); #1;
    endtask

    task automatic t_directed;
        t_op(1, 3, 145, 0, 3, 432, 0, -1, 0);   // 432-145 = 287
        t_op(1, 3, 432, 0, 3, 145, 0, -1, 0);   // 145-432 = -287
        t_op(0, 2, 17, 1, 2, 25, 1, -1, 0);     // -25 + -17 = -42
        t_op(0, 1, 7, 0, 2, 95, 0, -1, 0);      // 95+7 wraps to 02
        t_op(1, 2, 55, 0, 2, 55, 0, -1, 0);     // equal: zero, positive
        t_op(0, 1, 3, 1, 1, 1, 0, -1, 0);       // 1 + -3 = -2, one digit
        t_op(1, 2, 40, 1, 2, 12, 1, -1, 0);     // -12 - -40 = 28
    endtask

    task automatic t_lengths;
        t_op(1, 1, 7, 0, 4, 1000, 0, -1, 0);    // short A: 993
        t_op(0, 5, 12345, 0, 1, 9, 0, -1, 0);   // long A truncated: 4
        t_op(1, 6, 100000, 0, 2, 3, 0, -1, 0);  // truncated A is 0: 3
    endtask

    task automatic t_odd_codes;
        t_op(0, 1, 4, 0, 1, 5, 0, 12, 0);       // code 1100 is 4
        t_op(0, 1, 7, 0, 2, 11, 0, 15, 0);      // code 1111 is 7
        t_op(1, 1, 0, 0, 1, 5, 0, 0, 0);        // code 0000 is 0
    endtask

    task automatic t_busy_ignore;
        t_op(1, 3, 250, 0, 3, 100, 0, -1, 1);
        t_op(0, 4, 1234, 0, 4, 4321, 0, -1, 1);
    endtask

    task automatic t_random;
        for (int k = 0; k < 40; k++) begin
            int la = 1 + int'($urandom % 8);
            int lb = 1 + int'($urandom % 8);
            longint ma = longint'($urandom) % p10(la);
            longint mb = longint'($urandom) % p10(lb);
            t_op(1'($urandom), la, ma, 1'($urandom), lb, mb, 1'($urandom), -1, 0);
        end
    endtask

    initial begin
        n_total = 0; n_fail = 0; cyc = 0;
        t_reset;
        t_directed;
        t_lengths;
        t_odd_codes;
        t_busy_ignore;
        t_random;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule